// File: doc/BRIEF.md
# Word-Programmable NOR Storage Controller with Fill Engine

This block sits in front of a small word-addressed storage array that behaves like NOR flash, together with a bank of user configuration words. A 32-bit control register port holds a two-bit permission register, a ready flag and four command registers. Separate word ports give read and write access to the storage array and to the configuration bank. All accesses are whole 32-bit words; there are no byte or halfword lanes.

Programming can only clear bits. Each accepted storage write stores the old word ANDed with the new value. To bring bits back to one, software erases: a single page, the whole array, or only the configuration bank. An erase runs as a fill engine that writes one word of all-ones per clock. While it runs, the ready register reads 0, and every write on any port is refused with an error pulse.

The configuration bank is reset by the same engine. After reset it fills the bank with all-ones, so the block reports not-ready for that many cycles.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the permission register (offset 0x04) reads 0. The ready register (offset 0x00) reads 0 while the bank is filled with all-ones, one word per clock, and reads 1 afterwards. Every bank word then reads 0xFFFFFFFF.
- R2: In the permission register, bit 0 is write-enable and bit 1 is erase-enable. A write keeps only these two bits, and bits 31:2 always read 0. Register reads return data in the cycle after `reg_rd`.
- R3: A storage write with write-enable set stores old AND new. A read issued from the second cycle after the write returns the result, and back-to-back writes to one word combine correctly. `mem_rdata` is valid in the cycle after `mem_rd`.
- R4: A storage write while write-enable is clear leaves the word unchanged and raises `err`.
- R5: Writing a byte address to either page-erase register (0x08 or 0x0C) clears the in-page offset bits. With erase-enable set, the fill engine writes all-ones to every word of that page, and ready reads 0 until it finishes.
- R6: A page-erase address whose page start is above the last full page is ignored: no error, no erase, and ready stays 1.
- R7: With erase-enable clear, a page-erase write, or a whole-erase write of the key value 1, changes nothing and raises `err`.
- R8: Writing the key 1 to the whole-erase register (0x10) with erase-enable set fills all storage and all bank words with all-ones. Any other value has no effect and raises no error.
- R9: Writing the key 1 to the bank-erase register (0x14) fills every bank word with all-ones, whatever erase-enable holds, and leaves storage unchanged. Any other value has no effect.
- R10: Bank words read back exactly what was last written to them, one cycle after `cfg_rd`. Bank writes are not ANDed.
- R11: A read or write at an undefined control offset, including a write to the ready register, raises `err`, and such a read returns 0. The page-erase and whole-erase registers read as 0 without error.
- R12: While an erase runs, every control register write, storage write and bank write is refused with `err` and has no effect. Reads are still served.
- R13: `err` is a single-cycle pulse in the cycle after the offending access, and it is low after a cycle with no faulty access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_addr | input | 8 | Control register byte offset |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data, one cycle latency |
| mem_wr | input | 1 | Storage program strobe |
| mem_rd | input | 1 | Storage read strobe |
| mem_addr | input | clog2(STORE_BYTES/4) | Storage word index |
| mem_wdata | input | 32 | Storage program data |
| mem_rdata | output | 32 | Storage read data, one cycle latency |
| cfg_wr | input | 1 | Configuration bank write strobe |
| cfg_rd | input | 1 | Configuration bank read strobe |
| cfg_addr | input | clog2(CFG_WORDS) | Configuration bank word index |
| cfg_wdata | input | 32 | Configuration bank write data |
| cfg_rdata | output | 32 | Configuration bank read data, one cycle latency |
| err | output | 1 | Error pulse for a refused or illegal access |

## Verification
The assertions check on every cycle that:
- an erase never starts while one is running, and a storage erase never starts without erase-enable;
- a pending program commit never collides with a fill write;
- storage writes that are busy or lack write-enable always produce an error pulse;
- the upper permission bits and the busy ready value read as zero.

Only the bench scenarios can show the data results: the AND accumulation of programmed words, which page a masked address erases and which pages it leaves alone, and that refused and keyless commands leave the storage and the bank intact.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  localparam logic [7:0] OFS_READY     = 8'h00;
  localparam logic [7:0] OFS_PERM      = 8'h04;
  localparam logic [7:0] OFS_PAGE_A    = 8'h08;
  localparam logic [7:0] OFS_PAGE_B    = 8'h0C;
  localparam logic [7:0] OFS_WIPE_ALL  = 8'h10;
  localparam logic [7:0] OFS_WIPE_CFG  = 8'h14;

  localparam int          BIT_WEN  = 0;
  localparam int          BIT_EEN  = 1;
  localparam logic [31:0] WIPE_KEY = 32'd1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_READY,
    SEL_PERM,
    SEL_PAGE,
    SEL_WIPE_ALL,
    SEL_WIPE_CFG
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_READY:              s = SEL_READY;
      OFS_PERM:               s = SEL_PERM;
      OFS_PAGE_A, OFS_PAGE_B: s = SEL_PAGE;
      OFS_WIPE_ALL:           s = SEL_WIPE_ALL;
      OFS_WIPE_CFG:           s = SEL_WIPE_CFG;
      default:                s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nvm_regs.sv
module nvm_regs
  import nvm_pkg::*;
#(
  parameter int STORE_BYTES = 4096,
  parameter int PAGE_BYTES  = 1024,
  parameter int CFG_WORDS   = 64,
  parameter int ST_AW       = $clog2(STORE_BYTES / 4),
  parameter int LW          = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  input  logic              mem_wr,
  input  logic              cfg_wr,
  output logic [31:0]       reg_rdata,
  output logic              err,
  output logic              start,
  output logic              job_store,
  output logic              job_cfg,
  output logic [ST_AW-1:0]  job_base,
  output logic [LW-1:0]     job_len,
  output logic              mem_wr_ok,
  output logic              cfg_wr_ok
);

  localparam int          STORE_WORDS = STORE_BYTES / 4;
  localparam int          PAGE_WORDS  = PAGE_BYTES / 4;
  localparam int          FULL_WORDS  = (STORE_WORDS > CFG_WORDS) ? STORE_WORDS : CFG_WORDS;
  localparam logic [31:0] PAGE_MASK   = ~(32'(PAGE_BYTES) - 32'd1);
  localparam logic [31:0] LAST_PAGE   = 32'(STORE_BYTES - PAGE_BYTES);

  logic [1:0]  perm_q;
  reg_sel_e    sel;
  logic [31:0] page_addr;
  logic        key_hit, wr_legal, go_wr;
  logic        start_page, start_all, start_cfg, err_c;
  logic        wen, een;

  assign wen = perm_q[BIT_WEN];
  assign een = perm_q[BIT_EEN];

  always_comb begin
    sel        = decode_ofs(reg_addr);
    page_addr  = reg_wdata & PAGE_MASK;
    key_hit    = (reg_wdata == WIPE_KEY);
    wr_legal   = (sel != SEL_NONE) && (sel != SEL_READY);
    go_wr      = reg_wr && wr_legal && !busy;
    start_page = go_wr && (sel == SEL_PAGE) && een && (page_addr <= LAST_PAGE);
    start_all  = go_wr && (sel == SEL_WIPE_ALL) && key_hit && een;
    start_cfg  = go_wr && (sel == SEL_WIPE_CFG) && key_hit;
    start      = start_page || start_all || start_cfg;
    job_store  = start_page || start_all;
    job_cfg    = start_all || start_cfg;
    job_base   = start_page ? page_addr[ST_AW+1:2] : '0;
    if (start_page)     job_len = LW'(PAGE_WORDS);
    else if (start_all) job_len = LW'(FULL_WORDS);
    else                job_len = LW'(CFG_WORDS);
    mem_wr_ok  = mem_wr && !busy && wen;
    cfg_wr_ok  = cfg_wr && !busy;
    err_c      = (reg_rd && (sel == SEL_NONE))
              || (reg_wr && !wr_legal)
              || (reg_wr && wr_legal && busy)
              || (go_wr && (sel == SEL_PAGE) && !een)
              || (go_wr && (sel == SEL_WIPE_ALL) && key_hit && !een)
              || (mem_wr && (busy || !wen))
              || (cfg_wr && busy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      perm_q    <= '0;
      reg_rdata <= '0;
      err       <= 1'b0;
    end else begin
      err <= err_c;
      if (go_wr && (sel == SEL_PERM)) perm_q <= reg_wdata[1:0];
      if (reg_rd) begin
        case (sel)
          SEL_READY: reg_rdata <= {31'b0, ~busy};
          SEL_PERM:  reg_rdata <= {30'b0, perm_q};
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/nvm_fill_seq.sv
module nvm_fill_seq #(
  parameter int CFG_WORDS = 64,
  parameter int ST_AW     = 10,
  parameter int CF_AW     = 6,
  parameter int LW        = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             job_store,
  input  logic             job_cfg,
  input  logic [ST_AW-1:0] job_base,
  input  logic [LW-1:0]    job_len,
  input  logic             stall,
  output logic             busy,
  output logic             st_we,
  output logic [ST_AW-1:0] st_waddr,
  output logic             cf_we,
  output logic [CF_AW-1:0] cf_waddr
);

  logic [LW-1:0]    idx_q, len_q;
  logic [ST_AW-1:0] base_q;
  logic             tgt_st_q, tgt_cf_q;
  logic             step;

  assign step     = busy && !stall;
  assign st_we    = step && tgt_st_q;
  assign cf_we    = step && tgt_cf_q && (idx_q < LW'(CFG_WORDS));
  assign st_waddr = base_q + idx_q[ST_AW-1:0];
  assign cf_waddr = idx_q[CF_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      idx_q    <= '0;
      len_q    <= LW'(CFG_WORDS);
      base_q   <= '0;
      tgt_st_q <= 1'b0;
      tgt_cf_q <= 1'b1;
    end else if (start) begin
      busy     <= 1'b1;
      idx_q    <= '0;
      len_q    <= job_len;
      base_q   <= job_base;
      tgt_st_q <= job_store;
      tgt_cf_q <= job_cfg;
    end else if (step) begin
      if (idx_q == len_q - LW'(1)) busy <= 1'b0;
      else                         idx_q <= idx_q + LW'(1);
    end
  end

endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int WORDS = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   data,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  output logic [31:0]   rdata,
  output logic          pend
);

  logic [31:0]   mem [WORDS];
  logic [AW-1:0] s1_addr, last_addr, waddr;
  logic [31:0]   s1_data, last_val, old_w, new_w, wdata;
  logic          last_v, we;

  always_comb begin
    old_w = (last_v && last_addr == s1_addr) ? last_val : rdata;
    new_w = old_w & s1_data;
    we    = pend || fill_we;
    waddr = pend ? s1_addr : fill_addr;
    wdata = pend ? new_w : '1;
  end

  always_ff @(posedge clk) begin
    if (rd_en || prog) rdata <= mem[addr];
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      last_v <= 1'b0;
    end else begin
      pend   <= prog;
      last_v <= pend;
    end
    if (prog) begin
      s1_addr <= addr;
      s1_data <= data;
    end
    if (pend) begin
      last_addr <= s1_addr;
      last_val  <= new_w;
    end
  end

endmodule

// File: rtl/nvm_cfg_bank.sv
module nvm_cfg_bank #(
  parameter int WORDS = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          bus_we,
  input  logic          rd_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  output logic [31:0]   rdata
);

  logic [31:0]   mem [WORDS];
  logic [AW-1:0] waddr;
  logic [31:0]   wdata;

  always_comb begin
    waddr = fill_we ? fill_addr : bus_addr;
    wdata = fill_we ? '1 : bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (fill_we || bus_we) mem[waddr] <= wdata;
    if (rd_en) rdata <= mem[bus_addr];
  end

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl #(
  parameter int STORE_BYTES = 4096,
  parameter int PAGE_BYTES  = 1024,
  parameter int CFG_WORDS   = 64
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                reg_wr,
  input  logic                                reg_rd,
  input  logic [7:0]                          reg_addr,
  input  logic [31:0]                         reg_wdata,
  output logic [31:0]                         reg_rdata,
  input  logic                                mem_wr,
  input  logic                                mem_rd,
  input  logic [$clog2(STORE_BYTES/4)-1:0]    mem_addr,
  input  logic [31:0]                         mem_wdata,
  output logic [31:0]                         mem_rdata,
  input  logic                                cfg_wr,
  input  logic                                cfg_rd,
  input  logic [$clog2(CFG_WORDS)-1:0]        cfg_addr,
  input  logic [31:0]                         cfg_wdata,
  output logic [31:0]                         cfg_rdata,
  output logic                                err
);

  localparam int STORE_WORDS = STORE_BYTES / 4;
  localparam int ST_AW       = $clog2(STORE_WORDS);
  localparam int CF_AW       = $clog2(CFG_WORDS);
  localparam int FULL_WORDS  = (STORE_WORDS > CFG_WORDS) ? STORE_WORDS : CFG_WORDS;
  localparam int LW          = $clog2(FULL_WORDS) + 1;

  logic             busy, start, job_store, job_cfg;
  logic [ST_AW-1:0] job_base, fill_st_addr;
  logic [LW-1:0]    job_len;
  logic             mem_wr_ok, cfg_wr_ok, pend;
  logic             fill_st_we, fill_cf_we;
  logic [CF_AW-1:0] fill_cf_addr;

  nvm_regs #(
    .STORE_BYTES(STORE_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .CFG_WORDS(CFG_WORDS), .ST_AW(ST_AW), .LW(LW)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy),
    .mem_wr(mem_wr), .cfg_wr(cfg_wr), .reg_rdata(reg_rdata), .err(err),
    .start(start), .job_store(job_store), .job_cfg(job_cfg),
    .job_base(job_base), .job_len(job_len),
    .mem_wr_ok(mem_wr_ok), .cfg_wr_ok(cfg_wr_ok)
  );

  nvm_fill_seq #(
    .CFG_WORDS(CFG_WORDS), .ST_AW(ST_AW), .CF_AW(CF_AW), .LW(LW)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .job_store(job_store),
    .job_cfg(job_cfg), .job_base(job_base), .job_len(job_len),
    .stall(pend), .busy(busy), .st_we(fill_st_we), .st_waddr(fill_st_addr),
    .cf_we(fill_cf_we), .cf_waddr(fill_cf_addr)
  );

  nvm_store #(.WORDS(STORE_WORDS), .AW(ST_AW)) u_store (
    .clk(clk), .rst(rst), .prog(mem_wr_ok), .rd_en(mem_rd),
    .addr(mem_addr), .data(mem_wdata), .fill_we(fill_st_we),
    .fill_addr(fill_st_addr), .rdata(mem_rdata), .pend(pend)
  );

  nvm_cfg_bank #(.WORDS(CFG_WORDS), .AW(CF_AW)) u_bank (
    .clk(clk), .bus_we(cfg_wr_ok), .rd_en(cfg_rd), .bus_addr(cfg_addr),
    .bus_wdata(cfg_wdata), .fill_we(fill_cf_we), .fill_addr(fill_cf_addr),
    .rdata(cfg_rdata)
  );

endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk
  import nvm_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        start,
  input logic        job_store,
  input logic        pend,
  input logic        fill_st_we,
  input logic [1:0]  perm,
  input logic        mem_wr,
  input logic        reg_rd,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        err
);

  // R12: a new erase is only accepted while idle
  p_start_idle_r12: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R7: storage erases need erase-enable
  p_store_erase_een_r7: assert property (@(posedge clk) disable iff (rst)
    (start && job_store) |-> perm[BIT_EEN]);

  // R3: a pending program commit never meets a fill write
  p_commit_no_fill_r3: assert property (@(posedge clk) disable iff (rst)
    pend |-> !fill_st_we);

  // R12: storage write while busy is refused with an error
  p_busy_write_err_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && busy) |=> err);

  // R4: storage write without write-enable raises an error
  p_nowen_err_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !perm[BIT_WEN]) |=> err);

  // R2: upper permission bits read as zero
  p_perm_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_PERM) |=> (reg_rdata[31:2] == 30'b0));

  // R11: misaligned offsets are undefined
  p_misaligned_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr[1:0] != 2'b00) |=> (err && reg_rdata == 32'b0));

  // R5: ready reads 0 while busy
  p_ready_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_READY && busy) |=> (reg_rdata == 32'b0));

endmodule

bind nvm_ctrl nvm_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .start(start), .job_store(job_store),
  .pend(pend), .fill_st_we(fill_st_we), .perm(u_regs.perm_q),
  .mem_wr(mem_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .err(err)
);

// File: tb/tb_nvm_ctrl.sv
module tb_nvm_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int SB = 4096;
  localparam int PB = 1024;
  localparam int CW = 64;
  localparam int SW = SB / 4;
  localparam int PW = PB / 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_wr = 0, mem_rd = 0;
  logic [9:0]  mem_addr = 0;
  logic [31:0] mem_wdata = 0, mem_rdata;
  logic        cfg_wr = 0, cfg_rd = 0;
  logic [5:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        err;

  logic [31:0] m_store [SW];
  logic [31:0] m_cfg   [CW];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nvm_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; e = err;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0; d = reg_rdata; e = err;
  endtask

  task automatic mem_write(input int a, input logic [31:0] d, input bit gap, output logic e);
    @(negedge clk);
    mem_wr = 1; mem_addr = 10'(a); mem_wdata = d;
    @(negedge clk);
    mem_wr = 0; e = err;
    if (gap) @(negedge clk);
  endtask

  task automatic mem_read(input int a, output logic [31:0] d);
    @(negedge clk);
    mem_rd = 1; mem_addr = 10'(a);
    @(negedge clk);
    mem_rd = 0; d = mem_rdata;
  endtask

  task automatic cfg_write(input int a, input logic [31:0] d, output logic e);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; e = err;
  endtask

  task automatic cfg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1; cfg_addr = 6'(a);
    @(negedge clk);
    cfg_rd = 0; d = cfg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] d;
    logic e;
    d = 0;
    for (int i = 0; i < 3000; i++) begin
      reg_read(8'h00, d, e);
      if (d == 32'd1) break;
    end
    chk(d == 32'd1, tag, d, 32'd1);
  endtask

  task automatic check_store(input int a, input string tag);
    logic [31:0] d;
    mem_read(a, d);
    chk(d === m_store[a], tag, d, m_store[a]);
  endtask

  task automatic check_cfg_all(input string tag);
    logic [31:0] d;
    for (int i = 0; i < CW; i++) begin
      cfg_read(i, d);
      chk(d === m_cfg[i], tag, d, m_cfg[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    int a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < CW; i++) m_cfg[i] = '1;

    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state and bank fill
    reg_read(8'h00, d, e);
    chk(d == 0, "R1 ready low during reset fill", d, 0);
    reg_read(8'h04, d, e);
    chk(d == 0, "R1 permission resets to zero", d, 0);
    wait_idle("R1 ready after reset fill");
    check_cfg_all("R1 bank all ones after reset");

    // R2: permission masking
    reg_write(8'h04, 32'hFFFF_FFFF, e);
    chk(e == 0, "R2 permission write no error", 32'(e), 0);
    reg_read(8'h04, d, e);
    chk(d == 32'd3, "R2 permission masked", d, 3);
    reg_write(8'h04, 32'hFFFF_FFFE, e);
    reg_read(8'h04, d, e);
    chk(d == 32'd2, "R2 erase-enable only", d, 2);

    // R8: whole erase to establish known storage
    reg_write(8'h10, 32'd1, e);
    chk(e == 0, "R8 whole erase accepted", 32'(e), 0);
    wait_idle("R8 whole erase completes");
    for (int i = 0; i < SW; i++) m_store[i] = '1;
    for (int i = 0; i < 16; i++) check_store(int'($urandom_range(SW - 1)), "R8 storage ones");

    // R3: random programming with AND accumulation
    reg_write(8'h04, 32'd1, e);
    for (int i = 0; i < 300; i++) begin
      a = int'($urandom_range(SW - 1));
      d = $urandom;
      mem_write(a, d, 1'($urandom_range(1)), e);
      chk(e == 0, "R3 program accepted", 32'(e), 0);
      m_store[a] = m_store[a] & d;
    end
    mem_write(7, 32'hF0F0_FFFF, 0, e); m_store[7] &= 32'hF0F0_FFFF;
    mem_write(7, 32'hFFFF_0F0F, 0, e); m_store[7] &= 32'hFFFF_0F0F;
    mem_write(7, 32'h7FFF_FFFF, 1, e); m_store[7] &= 32'h7FFF_FFFF;
    check_store(7, "R3 back-to-back AND");
    for (int i = 0; i < 64; i++) check_store(int'($urandom_range(SW - 1)), "R3 programmed word");

    // R7: erases refused without erase-enable
    reg_write(8'h08, 32'd0, e);
    chk(e == 1, "R7 page erase without enable errors", 32'(e), 1);
    reg_write(8'h10, 32'd1, e);
    chk(e == 1, "R7 whole erase without enable errors", 32'(e), 1);
    reg_read(8'h00, d, e);
    chk(d == 1, "R7 no erase started", d, 1);
    check_store(7, "R7 storage unchanged");

    // R4: program refused without write-enable
    reg_write(8'h04, 32'd2, e);
    mem_write(7, 32'h0, 1, e);
    chk(e == 1, "R4 program without enable errors", 32'(e), 1);
    check_store(7, "R4 storage unchanged");

    // R13: err falls after an idle cycle
    @(negedge clk);
    chk(err == 0, "R13 err is a pulse", 32'(err), 0);

    // R5 / R12: page erase with masked address, writes refused while busy
    reg_write(8'h04, 32'd3, e);
    reg_write(8'h08, 32'(2 * PB + 32'h123), e);
    chk(e == 0, "R5 page erase accepted", 32'(e), 0);
    reg_read(8'h00, d, e);
    chk(d == 0, "R5 ready low during page erase", d, 0);
    mem_write(3, 32'h0, 0, e);
    chk(e == 1, "R12 program while busy errors", 32'(e), 1);
    cfg_write(3, 32'h0, e);
    chk(e == 1, "R12 bank write while busy errors", 32'(e), 1);
    reg_write(8'h04, 32'd0, e);
    chk(e == 1, "R12 register write while busy errors", 32'(e), 1);
    reg_read(8'h04, d, e);
    chk(d == 3 && e == 0, "R12 read served while busy", d, 3);
    wait_idle("R5 page erase completes");
    for (int i = 2 * PW; i < 3 * PW; i++) m_store[i] = '1;
    for (int i = 2 * PW; i < 3 * PW; i += 17) check_store(i, "R5 page two erased");
    check_store(3, "R12 refused program left word");
    check_store(7, "R5 other page intact");
    for (int i = 0; i < 16; i++) check_store(int'($urandom_range(SW - 1)), "R5 storage after page erase");
    cfg_read(3, d);
    chk(d == m_cfg[3], "R12 refused bank write", d, m_cfg[3]);

    // R5 via second register, last page; R6 beyond range
    reg_write(8'h0C, 32'(SB - PB + 4), e);
    chk(e == 0, "R5 last page erase accepted", 32'(e), 0);
    wait_idle("R5 last page completes");
    for (int i = 3 * PW; i < 4 * PW; i++) m_store[i] = '1;
    check_store(SW - 1, "R5 last page erased");
    check_store(3 * PW, "R5 last page start erased");
    reg_write(8'h0C, 32'(SB), e);
    chk(e == 0, "R6 out of range no error", 32'(e), 0);
    reg_read(8'h00, d, e);
    chk(d == 1, "R6 out of range no erase", d, 1);
    reg_write(8'h08, 32'hFFFF_FC00, e);
    reg_read(8'h00, d, e);
    chk(d == 1 && e == 0, "R6 high address ignored", d, 1);
    check_store(7, "R6 storage unchanged");

    // R10: bank read/write
    for (int i = 0; i < 20; i++) begin
      a = int'($urandom_range(CW - 1));
      d = $urandom;
      cfg_write(a, d, e);
      chk(e == 0, "R10 bank write accepted", 32'(e), 0);
      m_cfg[a] = d;
    end
    cfg_write(5, 32'h0000_00FF, e); m_cfg[5] = 32'h0000_00FF;
    cfg_write(5, 32'hAB00_0000, e); m_cfg[5] = 32'hAB00_0000;
    check_cfg_all("R10 bank readback");

    // R9: bank erase
    reg_write(8'h14, 32'd2, e);
    chk(e == 0, "R9 wrong key no error", 32'(e), 0);
    reg_read(8'h00, d, e);
    chk(d == 1, "R9 wrong key no erase", d, 1);
    cfg_read(5, d);
    chk(d == m_cfg[5], "R9 wrong key bank intact", d, m_cfg[5]);
    reg_write(8'h04, 32'd0, e);
    reg_write(8'h14, 32'd1, e);
    chk(e == 0, "R9 bank erase without enable", 32'(e), 0);
    wait_idle("R9 bank erase completes");
    for (int i = 0; i < CW; i++) m_cfg[i] = '1;
    check_cfg_all("R9 bank all ones");
    check_store(7, "R9 storage unchanged");

    // R8: whole erase key handling
    reg_write(8'h04, 32'd3, e);
    mem_write(11, 32'h1234_0000, 1, e); m_store[11] &= 32'h1234_0000;
    cfg_write(9, 32'h5555_AAAA, e); m_cfg[9] = 32'h5555_AAAA;
    reg_write(8'h10, 32'd5, e);
    chk(e == 0, "R8 wrong key no error", 32'(e), 0);
    reg_read(8'h00, d, e);
    chk(d == 1, "R8 wrong key no erase", d, 1);
    check_store(11, "R8 wrong key storage intact");
    reg_write(8'h10, 32'd1, e);
    wait_idle("R8 whole erase completes");
    for (int i = 0; i < SW; i++) m_store[i] = '1;
    for (int i = 0; i < CW; i++) m_cfg[i] = '1;
    check_store(11, "R8 storage erased");
    check_store(7, "R8 storage erased");
    check_cfg_all("R8 bank erased");

    // R11: undefined offsets
    reg_read(8'h18, d, e);
    chk(d == 0 && e == 1, "R11 undefined read", {d[30:0], e}, 32'd1);
    reg_read(8'h06, d, e);
    chk(d == 0 && e == 1, "R11 misaligned read", {d[30:0], e}, 32'd1);
    reg_write(8'h00, 32'd0, e);
    chk(e == 1, "R11 write to ready errors", 32'(e), 1);
    reg_write(8'h40, 32'd0, e);
    chk(e == 1, "R11 undefined write errors", 32'(e), 1);
    reg_read(8'h04, d, e);
    chk(d == 3, "R11 permission unchanged", d, 3);
    reg_read(8'h08, d, e);
    chk(d == 0 && e == 0, "R11 command register reads zero", {d[30:0], e}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule